// File: doc/BRIEF.md
# SPI NAND Page Access Controller

This block converts page-level requests (read a page, program a page, erase a block) into the ordered command steps that a serial NAND device with an internal cache needs. Each step is handed to a downstream phase sequencer as one descriptor. The descriptor holds an opcode, an address field with its byte count, a dummy byte count, a data direction, a lane count and a data length. The sequencer performs the serial transfer and answers with a completion strobe. For status reads, the strobe comes with the first received byte.

A read moves the array page into the device cache. It then polls the status feature register until the device reports ready, and streams the cache out in plain, fast or quad mode. A program writes the cache and commits it to the array. An erase clears one block. Both program and erase are preceded by a write-enable command. Every operation ends with a single-cycle completion pulse and a 3-bit result code. The code is taken from the status byte, or from a poll budget that the caller sets for each request. Only one request runs at a time. Requests that arrive while busy are refused, and so are requests with an undefined encoding.

Top module: `spinand_page_ctrl`

## Requirements
- R1: After reset, `busy`, `seq_valid`, `done` and `req_reject` are all 0.
- R2: A read (`req_op`=0) first issues opcode 0x13 with the row as a 3-byte address, no dummy and no data (dir 0). After the ready poll it issues a cache read with a 2-byte column address, DUMMY_BYTES dummy bytes, data in (dir 1) of `req_len` bytes. The cache read uses opcode 0x03 on 1 lane when `req_rmode`=0, 0x0B on 1 lane when `req_rmode`=1, and 0x6B on 4 lanes when `req_rmode`=2.
- R3: Each status poll is opcode 0x0F with address 0xC0 (1 address byte) and 1 data byte in on 1 lane. Polls repeat while bit 0 of the returned byte is 1.
- R4: For a read, the result is taken from bits 5:4 of the first not-busy status byte: 0 gives OK (0), 1 gives corrected (1), and 2 or 3 give uncorrectable (2).
- R5: A program (`req_op`=1) issues 0x06 (no address, no data), then 0x02 with a 2-byte column and `req_len` bytes out (dir 2), then 0x10 with a 3-byte row, then polls. Status bit 3 gives program-fail (3), otherwise OK. Bit 2 is ignored.
- R6: An erase (`req_op`=2) issues 0x06, then 0xD8 with a 3-byte row, then polls. Status bit 2 gives erase-fail (4), otherwise OK. Bit 3 is ignored.
- R7: A timeout occurs when poll number k (counted from 1) returns busy and k ≥ `poll_limit`, so at most max(`poll_limit`,1) polls are issued. The request then ends with result 5 and no further command; a read does not fetch the cache.
- R8: `done` is high for exactly one cycle, the cycle after the final `seq_done`. It comes with `result`, and `busy` is 0 in that cycle.
- R9: `req_valid` seen while busy, with `req_op`=3, or with a read using `req_rmode`=3, gives a one-cycle `req_reject` on the next cycle. It starts no command and leaves any request in flight unchanged.
- R10: `seq_valid` and all descriptor fields stay steady until `seq_done`. `seq_valid` is then low for at least one cycle before the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_rmode | input | 2 | Cache read mode: 0 plain, 1 fast, 2 quad |
| req_row | input | ROW_W | Page/block row address |
| req_col | input | COL_W | Column (byte offset in page) |
| req_len | input | LEN_W | Cache transfer length in bytes |
| poll_limit | input | CNT_W | Status poll budget for this request |
| req_reject | output | 1 | Request refused |
| busy | output | 1 | A request is in flight |
| seq_valid | output | 1 | Descriptor valid to the sequencer |
| seq_opcode | output | 8 | Command opcode |
| seq_addr | output | ADDR_W | Address value |
| seq_addr_bytes | output | 3 | Address byte count |
| seq_dummy_bytes | output | 3 | Dummy byte count |
| seq_dir | output | 2 | Data direction: 0 none, 1 in, 2 out |
| seq_lanes | output | 3 | Data lanes (1 or 4) |
| seq_len | output | LEN_W | Data byte count |
| seq_done | input | 1 | Sequencer finished the descriptor |
| seq_rdata | input | 8 | First received byte (status) |
| done | output | 1 | Request completion pulse |
| result | output | 3 | Result code |

## Verification
The assertions assume that the sequencer raises `seq_done` only while `seq_valid` is high, and only for a single cycle. They also assume that `seq_rdata` is meaningful in that cycle. The bench's sequencer model follows this contract. It waits for `seq_valid`, holds a random delay of zero to two cycles, pulses `seq_done` once, and then waits for the gap that must follow. Busy-status counts and poll budgets are drawn so that both outcomes occur: sometimes the budget runs out and sometimes readiness arrives first, including the exact-limit boundary and a zero budget.

// File: rtl/spinand_ctrl_pkg.sv
// Shared encodings for the serial NAND page access controller.
// Assumes a single-die device with an on-die cache and a status feature register.
package spinand_ctrl_pkg;
    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_PROG  = 2'd1;
    localparam logic [1:0] OP_ERASE = 2'd2;

    localparam logic [1:0] RMODE_PLAIN = 2'd0;
    localparam logic [1:0] RMODE_FAST  = 2'd1;
    localparam logic [1:0] RMODE_QUAD  = 2'd2;

    typedef enum logic [2:0] {
        STEP_WREN,
        STEP_ARRAY_RD,
        STEP_POLL,
        STEP_CACHE_RD,
        STEP_CACHE_WR,
        STEP_EXEC,
        STEP_ERASE
    } step_e;

    localparam logic [7:0] OPC_WREN     = 8'h06;
    localparam logic [7:0] OPC_ARRAY_RD = 8'h13;
    localparam logic [7:0] OPC_RD_PLAIN = 8'h03;
    localparam logic [7:0] OPC_RD_FAST  = 8'h0B;
    localparam logic [7:0] OPC_RD_QUAD  = 8'h6B;
    localparam logic [7:0] OPC_GET_FEAT = 8'h0F;
    localparam logic [7:0] OPC_CACHE_WR = 8'h02;
    localparam logic [7:0] OPC_EXEC     = 8'h10;
    localparam logic [7:0] OPC_ERASE    = 8'hD8;
    localparam logic [7:0] STATUS_REG   = 8'hC0;

    localparam logic [1:0] DIR_NONE = 2'd0;
    localparam logic [1:0] DIR_IN   = 2'd1;
    localparam logic [1:0] DIR_OUT  = 2'd2;

    localparam logic [2:0] RES_OK        = 3'd0;
    localparam logic [2:0] RES_ECC_FIX   = 3'd1;
    localparam logic [2:0] RES_ECC_BAD   = 3'd2;
    localparam logic [2:0] RES_PROG_FAIL = 3'd3;
    localparam logic [2:0] RES_ERASE_FAIL= 3'd4;
    localparam logic [2:0] RES_TIMEOUT   = 3'd5;
endpackage

// File: rtl/spinand_cmd_fmt.sv
// Command descriptor formatter.
// Maps the current step plus the latched request into one sequencer descriptor.
// Assumes ADDR_W is at least 8 and at least as wide as row and column.
module spinand_cmd_fmt
    import spinand_ctrl_pkg::*;
#(
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int LEN_W       = 16,
    parameter int ADDR_W      = 24,
    parameter int DUMMY_BYTES = 1
) (
    input  step_e              step,
    input  logic [1:0]         rmode,
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   col,
    input  logic [LEN_W-1:0]   len,
    output logic [7:0]         opcode,
    output logic [ADDR_W-1:0]  addr,
    output logic [2:0]         addr_bytes,
    output logic [2:0]         dummy_bytes,
    output logic [1:0]         dir,
    output logic [2:0]         lanes,
    output logic [LEN_W-1:0]   dlen
);
    localparam int ROW_BYTES = (ROW_W + 7) / 8;
    localparam int COL_BYTES = (COL_W + 7) / 8;

    // Select the fields of the descriptor for the current step.
    always_comb begin
        opcode      = 8'h00;
        addr        = '0;
        addr_bytes  = 3'd0;
        dummy_bytes = 3'd0;
        dir         = DIR_NONE;
        lanes       = 3'd1;
        dlen        = '0;
        case (step)
            STEP_WREN: opcode = OPC_WREN;
            STEP_ARRAY_RD: begin
                opcode     = OPC_ARRAY_RD;
                addr       = ADDR_W'(row);
                addr_bytes = 3'(ROW_BYTES);
            end
            STEP_POLL: begin
                opcode     = OPC_GET_FEAT;
                addr       = ADDR_W'(STATUS_REG);
                addr_bytes = 3'd1;
                dir        = DIR_IN;
                dlen       = LEN_W'(1);
            end
            STEP_CACHE_RD: begin
                case (rmode)
                    RMODE_FAST: opcode = OPC_RD_FAST;
                    RMODE_QUAD: opcode = OPC_RD_QUAD;
                    default:    opcode = OPC_RD_PLAIN;
                endcase
                lanes       = (rmode == RMODE_QUAD) ? 3'd4 : 3'd1;
                addr        = ADDR_W'(col);
                addr_bytes  = 3'(COL_BYTES);
                dummy_bytes = 3'(DUMMY_BYTES);
                dir         = DIR_IN;
                dlen        = len;
            end
            STEP_CACHE_WR: begin
                opcode     = OPC_CACHE_WR;
                addr       = ADDR_W'(col);
                addr_bytes = 3'(COL_BYTES);
                dir        = DIR_OUT;
                dlen       = len;
            end
            STEP_EXEC: begin
                opcode     = OPC_EXEC;
                addr       = ADDR_W'(row);
                addr_bytes = 3'(ROW_BYTES);
            end
            STEP_ERASE: begin
                opcode     = OPC_ERASE;
                addr       = ADDR_W'(row);
                addr_bytes = 3'(ROW_BYTES);
            end
            default: opcode = 8'h00;
        endcase
    end
endmodule

// File: rtl/spinand_poll_tracker.sv
// Status poll budget tracker.
// Counts busy answers in the current request and flags expiry when the busy
// answer just received is number limit or later. Assumes limit changes only
// together with clear.
module spinand_poll_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             busy_poll,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_cnt;

    // Number of this busy answer, counted from 1.
    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign expire   = busy_poll && (next_cnt >= {1'b0, limit});

    // Advance the busy counter while the budget lasts.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clear)              cnt_q <= '0;
        else if (busy_poll && !expire) cnt_q <= next_cnt[CNT_W-1:0];
    end

    // R7
    poll_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q < limit));
endmodule

// File: rtl/spinand_status_eval.sv
// Status byte evaluator.
// Turns the final ready status byte into a result code according to the
// operation kind: ECC field for reads, failure flags for program and erase.
module spinand_status_eval
    import spinand_ctrl_pkg::*;
(
    input  logic [1:0] op,
    input  logic [5:2] flags,
    output logic [2:0] res
);
    // Decode the bits that matter for this operation.
    always_comb begin
        res = RES_OK;
        case (op)
            OP_READ: begin
                case (flags[5:4])
                    2'd0:    res = RES_OK;
                    2'd1:    res = RES_ECC_FIX;
                    default: res = RES_ECC_BAD;
                endcase
            end
            OP_PROG:  res = flags[3] ? RES_PROG_FAIL  : RES_OK;
            OP_ERASE: res = flags[2] ? RES_ERASE_FAIL : RES_OK;
            default:  res = RES_OK;
        endcase
    end
endmodule

// File: rtl/spinand_page_ctrl.sv
// Serial NAND page access controller (top).
// Accepts one read/program/erase request at a time and walks the command
// steps through a descriptor port: a descriptor stays valid until the
// sequencer pulses seq_done, then valid drops for one cycle. Assumes seq_done
// is a single-cycle pulse given only while seq_valid is high.
module spinand_page_ctrl
    import spinand_ctrl_pkg::*;
#(
    parameter int ROW_W       = 24,
    parameter int COL_W       = 16,
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 16,
    parameter int DUMMY_BYTES = 1,
    localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_rmode,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic              req_reject,
    output logic              busy,
    output logic              seq_valid,
    output logic [7:0]        seq_opcode,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [2:0]        seq_addr_bytes,
    output logic [2:0]        seq_dummy_bytes,
    output logic [1:0]        seq_dir,
    output logic [2:0]        seq_lanes,
    output logic [LEN_W-1:0]  seq_len,
    input  logic              seq_done,
    input  logic [7:0]        seq_rdata,
    output logic              done,
    output logic [2:0]        result
);
    logic             busy_q, issuing_q, done_q, reject_q, wren_seen_q;
    step_e            step_q;
    logic [1:0]       op_q, rmode_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] limit_q;
    logic [2:0]       ecc_res_q, result_q, eval_res;
    logic             illegal, accept, step_end, busy_poll, expire;
    logic             unused_rdata;

    assign illegal   = (req_op == 2'd3) || (req_op == OP_READ && req_rmode == 2'd3);
    assign accept    = req_valid && !busy_q && !illegal;
    assign step_end  = busy_q && issuing_q && seq_done;
    assign busy_poll = step_end && (step_q == STEP_POLL) && seq_rdata[0];
    assign unused_rdata = ^{seq_rdata[7:6], seq_rdata[1]};

    spinand_cmd_fmt #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W),
        .ADDR_W(ADDR_W), .DUMMY_BYTES(DUMMY_BYTES)
    ) u_fmt (
        .step(step_q), .rmode(rmode_q), .row(row_q), .col(col_q), .len(len_q),
        .opcode(seq_opcode), .addr(seq_addr), .addr_bytes(seq_addr_bytes),
        .dummy_bytes(seq_dummy_bytes), .dir(seq_dir), .lanes(seq_lanes),
        .dlen(seq_len)
    );

    spinand_poll_tracker #(.CNT_W(CNT_W)) u_poll (
        .clk(clk), .rst_n(rst_n), .clear(accept), .busy_poll(busy_poll),
        .limit(limit_q), .expire(expire)
    );

    spinand_status_eval u_eval (
        .op(op_q), .flags(seq_rdata[5:2]), .res(eval_res)
    );

    // Request intake, step sequencing and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            issuing_q   <= 1'b0;
            done_q      <= 1'b0;
            reject_q    <= 1'b0;
            wren_seen_q <= 1'b0;
            step_q      <= STEP_WREN;
            op_q        <= OP_READ;
            rmode_q     <= RMODE_PLAIN;
            row_q       <= '0;
            col_q       <= '0;
            len_q       <= '0;
            limit_q     <= '0;
            ecc_res_q   <= RES_OK;
            result_q    <= RES_OK;
        end else begin
            done_q   <= 1'b0;
            reject_q <= req_valid && (busy_q || illegal);
            if (accept) begin
                busy_q      <= 1'b1;
                issuing_q   <= 1'b1;
                wren_seen_q <= 1'b0;
                op_q        <= req_op;
                rmode_q     <= req_rmode;
                row_q       <= req_row;
                col_q       <= req_col;
                len_q       <= req_len;
                limit_q     <= poll_limit;
                step_q      <= (req_op == OP_READ) ? STEP_ARRAY_RD : STEP_WREN;
            end else if (busy_q && !issuing_q) begin
                issuing_q <= 1'b1;
            end else if (step_end) begin
                issuing_q <= 1'b0;
                case (step_q)
                    STEP_WREN: begin
                        wren_seen_q <= 1'b1;
                        step_q <= (op_q == OP_PROG) ? STEP_CACHE_WR : STEP_ERASE;
                    end
                    STEP_ARRAY_RD, STEP_EXEC, STEP_ERASE: step_q <= STEP_POLL;
                    STEP_CACHE_WR: step_q <= STEP_EXEC;
                    STEP_POLL: begin
                        if (seq_rdata[0]) begin
                            if (expire) begin
                                busy_q   <= 1'b0;
                                done_q   <= 1'b1;
                                result_q <= RES_TIMEOUT;
                            end
                        end else if (op_q == OP_READ) begin
                            ecc_res_q <= eval_res;
                            step_q    <= STEP_CACHE_RD;
                        end else begin
                            busy_q   <= 1'b0;
                            done_q   <= 1'b1;
                            result_q <= eval_res;
                        end
                    end
                    STEP_CACHE_RD: begin
                        busy_q   <= 1'b0;
                        done_q   <= 1'b1;
                        result_q <= ecc_res_q;
                    end
                    default: begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        result_q <= RES_OK;
                    end
                endcase
            end
        end
    end

    assign busy       = busy_q;
    assign seq_valid  = busy_q && issuing_q;
    assign done       = done_q;
    assign result     = result_q;
    assign req_reject = reject_q;

    // R10
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && !seq_done) |=> (seq_valid && $stable(seq_opcode) &&
                                      $stable(seq_addr) && $stable(seq_len)));
    // R10
    seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_done) |=> !seq_valid);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && result <= RES_TIMEOUT));
    // R5
    exec_after_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_opcode == OPC_EXEC) |-> wren_seen_q);
    // R6
    erase_after_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_opcode == OPC_ERASE) |-> wren_seen_q);
    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> $past(req_valid));
endmodule

// File: tb/spinand_page_ctrl_test.sv
// Bench: sequencer model plus expected command lists built from the requirements.
module spinand_page_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DUMMY      = 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0, req_rmode = '0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0, req_len = '0, poll_limit = '0;
    logic        req_reject, busy, seq_valid, done;
    logic [7:0]  seq_opcode;
    logic [23:0] seq_addr;
    logic [2:0]  seq_addr_bytes, seq_dummy_bytes, seq_lanes, result;
    logic [1:0]  seq_dir;
    logic [15:0] seq_len;
    logic        seq_done = 1'b0;
    logic [7:0]  seq_rdata = '0;

    int nvec = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spinand_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_rmode(req_rmode), .req_row(req_row), .req_col(req_col),
        .req_len(req_len), .poll_limit(poll_limit), .req_reject(req_reject),
        .busy(busy), .seq_valid(seq_valid), .seq_opcode(seq_opcode),
        .seq_addr(seq_addr), .seq_addr_bytes(seq_addr_bytes),
        .seq_dummy_bytes(seq_dummy_bytes), .seq_dir(seq_dir),
        .seq_lanes(seq_lanes), .seq_len(seq_len), .seq_done(seq_done),
        .seq_rdata(seq_rdata), .done(done), .result(result)
    );

    // Expected descriptor list for one request.
    logic [7:0]  e_opc [32];
    logic [23:0] e_addr [32];
    logic [2:0]  e_alen [32], e_dum [32], e_lanes [32];
    logic [1:0]  e_dir [32];
    logic [15:0] e_dlen [32];
    logic [7:0]  e_rd [32];
    string       e_tag [32];
    int          e_n;
    logic [2:0]  e_res;
    string       e_rtag;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [7:0] opc, input logic [23:0] a,
                        input int alen, input int dum, input logic [1:0] dir,
                        input int lanes, input logic [15:0] dlen, input logic [7:0] rd);
        e_tag[e_n] = tag; e_opc[e_n] = opc; e_addr[e_n] = a;
        e_alen[e_n] = 3'(alen); e_dum[e_n] = 3'(dum); e_dir[e_n] = dir;
        e_lanes[e_n] = 3'(lanes); e_dlen[e_n] = dlen; e_rd[e_n] = rd;
        e_n++;
    endtask

    function automatic logic [2:0] decode(input logic [1:0] op, input logic [7:0] st);
        if (op == 2'd0) return (st[5:4] == 2'd0) ? 3'd0 : (st[5:4] == 2'd1) ? 3'd1 : 3'd2;
        if (op == 2'd1) return st[3] ? 3'd3 : 3'd0;
        return st[2] ? 3'd4 : 3'd0;
    endfunction

    // Build the command list and result the requirements call for.
    task automatic build(input logic [1:0] op, input logic [1:0] rm, input logic [23:0] row,
                         input logic [15:0] col, input logic [15:0] len, input int limit,
                         input int nbusy, input logic [7:0] fstat);
        int  cap;
        bit  tmo;
        string ot;
        e_n = 0;
        cap = (limit < 1) ? 1 : limit;
        tmo = (nbusy >= cap);
        ot  = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R5" : "R6";
        if (op == 2'd0) push("R2 array load", 8'h13, row, 3, 0, 2'd0, 1, 16'd0, 8'h00);
        else begin
            push({ot, " wren"}, 8'h06, 24'd0, 0, 0, 2'd0, 1, 16'd0, 8'h00);
            if (op == 2'd1) begin
                push("R5 cache load", 8'h02, {8'd0, col}, 2, 0, 2'd2, 1, len, 8'h00);
                push("R5 exec", 8'h10, row, 3, 0, 2'd0, 1, 16'd0, 8'h00);
            end else push("R6 erase", 8'hD8, row, 3, 0, 2'd0, 1, 16'd0, 8'h00);
        end
        for (int i = 0; i < (tmo ? cap : nbusy); i++)
            push("R3 poll busy", 8'h0F, 24'hC0, 1, 0, 2'd1, 1, 16'd1,
                 {7'($urandom), 1'b1});
        if (tmo) begin
            e_res = 3'd5; e_rtag = "R7 timeout result";
        end else begin
            push("R3 poll ready", 8'h0F, 24'hC0, 1, 0, 2'd1, 1, 16'd1, {fstat[7:1], 1'b0});
            if (op == 2'd0)
                push("R2 cache read", (rm == 2'd0) ? 8'h03 : (rm == 2'd1) ? 8'h0B : 8'h6B,
                     {8'd0, col}, 2, DUMMY, 2'd1, (rm == 2'd2) ? 4 : 1, len, 8'h00);
            e_res  = decode(op, fstat);
            e_rtag = (op == 2'd0) ? "R4 read result" : (op == 2'd1) ? "R5 result" : "R6 result";
        end
    endtask

    // Issue one request, serve its descriptors and check every step.
    task automatic run_req(input logic [1:0] op, input logic [1:0] rm, input logic [23:0] row,
                           input logic [15:0] col, input logic [15:0] len, input int limit,
                           input int nbusy, input logic [7:0] fstat, input bit inj);
        build(op, rm, row, col, len, limit, nbusy, fstat);
        @(negedge clk);
        req_op = op; req_rmode = rm; req_row = row; req_col = col; req_len = len;
        poll_limit = 16'(limit); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 legal request not refused", {31'd0, req_reject}, 0);
        for (int k = 0; k < e_n; k++) begin
            while (!seq_valid) @(negedge clk);
            if (inj && k == 0) begin
                req_valid = 1'b1; req_op = 2'd2;
                @(negedge clk);
                req_valid = 1'b0;
                chk("R9 refused while busy", {31'd0, req_reject}, 1);
            end
            chk({e_tag[k], " opcode"}, {24'd0, seq_opcode}, {24'd0, e_opc[k]});
            chk({e_tag[k], " addr"}, {8'd0, seq_addr}, {8'd0, e_addr[k]});
            chk({e_tag[k], " addr bytes"}, {29'd0, seq_addr_bytes}, {29'd0, e_alen[k]});
            chk({e_tag[k], " dummy"}, {29'd0, seq_dummy_bytes}, {29'd0, e_dum[k]});
            chk({e_tag[k], " dir"}, {30'd0, seq_dir}, {30'd0, e_dir[k]});
            chk({e_tag[k], " lanes"}, {29'd0, seq_lanes}, {29'd0, e_lanes[k]});
            chk({e_tag[k], " len"}, {16'd0, seq_len}, {16'd0, e_dlen[k]});
            repeat ($urandom % 3) @(negedge clk);
            chk("R10 descriptor held", {31'd0, seq_valid}, 1);
            seq_done = 1'b1; seq_rdata = e_rd[k];
            @(negedge clk);
            seq_done = 1'b0;
            if (k == e_n - 1) begin
                chk("R8 done pulse", {31'd0, done}, 1);
                chk(e_rtag, {29'd0, result}, {29'd0, e_res});
                chk("R8 idle at done", {31'd0, busy}, 0);
            end else begin
                chk("R8 no early done", {31'd0, done}, 0);
                chk("R10 gap between descriptors", {31'd0, seq_valid}, 0);
            end
        end
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, done}, 0);
        chk("R7 no command after end", {31'd0, seq_valid}, 0);
    endtask

    // Present an undefined encoding while idle and expect a refusal.
    task automatic illegal_req(input logic [1:0] op, input logic [1:0] rm);
        @(negedge clk);
        req_op = op; req_rmode = rm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 undefined encoding refused", {31'd0, req_reject}, 1);
        chk("R9 stays idle", {31'd0, busy}, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no descriptor", {31'd0, seq_valid}, 0);
        end
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog: actual=hung expected=progress");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {31'd0, busy}, 0);
        chk("R1 seq_valid after reset", {31'd0, seq_valid}, 0);
        chk("R1 done after reset", {31'd0, done}, 0);
        chk("R1 reject after reset", {31'd0, req_reject}, 0);

        // Directed corner cases.
        run_req(2'd0, 2'd0, 24'h012345, 16'h0800, 16'd2048, 5, 2, 8'h00, 0); // R4 clean
        run_req(2'd0, 2'd1, 24'hABCDEF, 16'h0010, 16'd64, 5, 0, 8'h10, 0);   // R4 fixed
        run_req(2'd0, 2'd2, 24'h000001, 16'h0000, 16'd4096, 4, 1, 8'h20, 1); // R4 bad, R9
        run_req(2'd0, 2'd0, 24'hFFFFFF, 16'hFFFF, 16'd1, 4, 1, 8'hF0, 0);    // R4 code 3
        run_req(2'd1, 2'd0, 24'h000100, 16'h0004, 16'd16, 4, 1, 8'h08, 0);   // R5 fail
        run_req(2'd1, 2'd3, 24'h000200, 16'h0000, 16'd32, 4, 0, 8'h04, 0);   // R5 ignores bit 2
        run_req(2'd2, 2'd0, 24'h000040, 16'h0000, 16'd0, 4, 2, 8'h04, 0);    // R6 fail
        run_req(2'd2, 2'd0, 24'h000080, 16'h0000, 16'd0, 4, 0, 8'h08, 0);    // R6 ignores bit 3
        run_req(2'd0, 2'd2, 24'h00AA00, 16'h0100, 16'd8, 3, 3, 8'h00, 0);    // R7 exact budget
        run_req(2'd2, 2'd0, 24'h00BB00, 16'h0000, 16'd0, 0, 1, 8'h00, 0);    // R7 zero budget
        run_req(2'd1, 2'd0, 24'h00CC00, 16'h0020, 16'd4, 4, 3, 8'h00, 0);    // R7 ready on last
        illegal_req(2'd3, 2'd0);
        illegal_req(2'd0, 2'd3);

        // Constrained random requests.
        for (int t = 0; t < 40; t++) begin
            logic [1:0] op, rm;
            op = 2'($urandom % 3);
            rm = 2'($urandom % 3);
            run_req(op, rm, 24'($urandom), 16'($urandom), 16'($urandom % 4096 + 1),
                    int'($urandom % 7), int'($urandom % 6), 8'($urandom), (t % 5) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule